// File: doc/BRIEF.md
# Indirect Register Access Bridge Across Clock Domains

This block lets a host reach a bank of 32-bit control and status registers that runs on its own clock. The host never touches that bank directly. It writes a command word that holds a start flag, a direction bit and an 8-bit register index, plus a data word. The bridge then carries the request into the register clock domain, strobes the register port once, and reports completion by clearing the start flag. The start flag doubles as a busy indicator.

The request and its completion cross the domains through a four-phase level handshake. Each direction passes through its own chain of synchronizer flops. The index, the direction and the write value sit in the host-side words. These are frozen while an access runs, so the multi-bit fields are stable whenever the register side samples them and need no per-bit synchronization. For a read, the register side latches the returned value and holds it until the host has copied it into the data word.

Top module: `csr_xdom_bridge`

## Requirements
- R1: After reset the command word and the data word both read as all zeros.
- R2: A host write to the command word with bit 31 set, while no access is running, sets bit 31 (busy) and produces exactly one register-port strobe (`reg_en` high for one `iclk` cycle). The strobe carries the index taken from bits 7:0 of that write on `reg_addr`.
- R3: A host write to the command word with bit 31 clear updates only the direction bit (30) and the index (7:0). It leaves busy at 0 and produces no strobe.
- R4: Bits 29:8 of the command word always read as zero, whatever value the host writes there.
- R5: When bit 30 is 0, the access is a write. The strobe has `reg_we` at 1, and `reg_wdata` equals the data word.
- R6: When bit 30 is 1, the access is a read. The strobe has `reg_we` at 0. `reg_rdata` is sampled `RD_LAT` `iclk` cycles after the strobe cycle, and that value is in the data word no later than the first host cycle in which busy reads 0.
- R7: Busy stays at 1 until the completion handshake has fully returned to idle, and then clears by itself. It is still 1 three host cycles after the start.
- R8: While busy is 1, host writes to either word are ignored. The command fields and the value sent or returned are those of the original request.
- R9: Accesses issued back to back, each started once busy has cleared, complete independently. A read returns the value written by the most recent write to the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain asynchronous reset, active low |
| h_wr | input | 1 | Host write strobe, one cycle per write |
| h_sel | input | 1 | Word select: 0 command word, 1 data word |
| h_wdata | input | 32 | Host write value |
| h_cmd | output | 32 | Command word read view: busy, direction, index |
| h_data | output | 32 | Data word read view |
| iclk | input | 1 | Register-bank clock |
| irst_n | input | 1 | Register-domain asynchronous reset, active low |
| reg_en | output | 1 | Register-port strobe, one cycle per access |
| reg_we | output | 1 | Register-port write enable, qualified by reg_en |
| reg_addr | output | 8 | Register index |
| reg_wdata | output | 32 | Register write value |
| reg_rdata | input | 32 | Register read value, valid RD_LAT cycles after the strobe |

## Verification
The hardest case to reach is the window between the moment the register side has sampled the read value and the moment busy drops. A wrong ordering there would let the host see busy clear while the data word still holds stale contents. The bench clocks the two domains at unrelated periods so that the synchronizer phase drifts from one access to the next. It polls busy every host cycle and compares the data word in the very first cycle busy reads 0. It also fires writes at both words in the middle of an access to show that the request stays frozen.

// File: rtl/csr_bridge_pkg.sv
`timescale 1ns/1ps
package csr_bridge_pkg;

   // host word select codes
   localparam logic SEL_CMD  = 1'b0;
   localparam logic SEL_DATA = 1'b1;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_REQ   = 2'd1,
      HS_DRAIN = 2'd2
   } host_st_e;

   typedef enum logic [1:0] {
      IS_IDLE   = 2'd0,
      IS_STROBE = 2'd1,
      IS_WAIT   = 2'd2,
      IS_ACK    = 2'd3
   } int_st_e;

endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hb_host_regs.sv
`timescale 1ns/1ps
module hb_host_regs
   import csr_bridge_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              hclk,
   input  logic              hrst_n,
   input  logic              h_wr,
   input  logic              h_sel,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              ack_s,
   input  logic [DATA_W-1:0] ret_data,
   output logic              req,
   output logic              busy,
   output logic              dir_rd,
   output logic [ADDR_W-1:0] idx,
   output logic [DATA_W-1:0] data_q
);

   localparam int BUSY_BIT = DATA_W - 1;
   localparam int DIR_BIT  = DATA_W - 2;

   host_st_e st;

   always_ff @(posedge hclk or negedge hrst_n) begin
      if (!hrst_n) begin
         st     <= HS_IDLE;
         req    <= 1'b0;
         dir_rd <= 1'b0;
         idx    <= '0;
         data_q <= '0;
      end else begin
         unique case (st)
            HS_IDLE: begin
               if (h_wr) begin
                  if (h_sel == SEL_CMD) begin
                     dir_rd <= h_wdata[DIR_BIT];
                     idx    <= h_wdata[ADDR_W-1:0];
                     if (h_wdata[BUSY_BIT]) begin
                        req <= 1'b1;
                        st  <= HS_REQ;
                     end
                  end else begin
                     data_q <= h_wdata;
                  end
               end
            end
            HS_REQ: begin
               if (ack_s) begin
                  if (dir_rd) data_q <= ret_data;
                  req <= 1'b0;
                  st  <= HS_DRAIN;
               end
            end
            HS_DRAIN: begin
               if (!ack_s) st <= HS_IDLE;
            end
            default: st <= HS_IDLE;
         endcase
      end
   end

   assign busy = (st != HS_IDLE);

endmodule

// File: rtl/hb_int_seq.sv
`timescale 1ns/1ps
module hb_int_seq
   import csr_bridge_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic              iclk,
   input  logic              irst_n,
   input  logic              req_s,
   input  logic              dir_rd,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              ack,
   output logic [DATA_W-1:0] ret_data,
   output logic              reg_en,
   output logic              reg_we
);

   localparam int CW = $clog2(RD_LAT) + 1;

   int_st_e       st;
   logic [CW-1:0] cnt;

   always_ff @(posedge iclk or negedge irst_n) begin
      if (!irst_n) begin
         st       <= IS_IDLE;
         cnt      <= '0;
         ack      <= 1'b0;
         ret_data <= '0;
      end else begin
         unique case (st)
            IS_IDLE: begin
               if (req_s) st <= IS_STROBE;
            end
            IS_STROBE: begin
               cnt <= CW'(RD_LAT - 1);
               st  <= IS_WAIT;
            end
            IS_WAIT: begin
               if (cnt == '0) begin
                  if (dir_rd) ret_data <= reg_rdata;
                  ack <= 1'b1;
                  st  <= IS_ACK;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            IS_ACK: begin
               if (!req_s) begin
                  ack <= 1'b0;
                  st  <= IS_IDLE;
               end
            end
            default: st <= IS_IDLE;
         endcase
      end
   end

   assign reg_en = (st == IS_STROBE);
   assign reg_we = reg_en & ~dir_rd;

endmodule

// File: rtl/csr_xdom_bridge.sv
`timescale 1ns/1ps
module csr_xdom_bridge
   import csr_bridge_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RD_LAT      = 1
) (
   input  logic              hclk,
   input  logic              hrst_n,
   input  logic              h_wr,
   input  logic              h_sel,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_cmd,
   output logic [DATA_W-1:0] h_data,
   input  logic              iclk,
   input  logic              irst_n,
   output logic              reg_en,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata
);

   localparam int BUSY_BIT = DATA_W - 1;
   localparam int DIR_BIT  = DATA_W - 2;

   if (DATA_W < ADDR_W + 2) begin : g_bad_width
      $error("csr_xdom_bridge: DATA_W too small for busy, direction and index");
   end
   if (RD_LAT < 1) begin : g_bad_lat
      $error("csr_xdom_bridge: RD_LAT must be at least 1");
   end

   logic              req, req_s, ack, ack_s, busy, dir_rd;
   logic [ADDR_W-1:0] idx;
   logic [DATA_W-1:0] data_q, ret_data;

   hb_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_host (
      .hclk(hclk), .hrst_n(hrst_n), .h_wr(h_wr), .h_sel(h_sel),
      .h_wdata(h_wdata), .ack_s(ack_s), .ret_data(ret_data),
      .req(req), .busy(busy), .dir_rd(dir_rd), .idx(idx), .data_q(data_q)
   );

   hb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(iclk), .rst_n(irst_n), .d(req), .q(req_s)
   );

   hb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(hclk), .rst_n(hrst_n), .d(ack), .q(ack_s)
   );

   hb_int_seq #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_seq (
      .iclk(iclk), .irst_n(irst_n), .req_s(req_s), .dir_rd(dir_rd),
      .reg_rdata(reg_rdata), .ack(ack), .ret_data(ret_data),
      .reg_en(reg_en), .reg_we(reg_we)
   );

   // fields held frozen by the host side while busy
   assign reg_addr  = idx;
   assign reg_wdata = data_q;
   assign h_data    = data_q;

   always_comb begin
      h_cmd               = '0;
      h_cmd[BUSY_BIT]     = busy;
      h_cmd[DIR_BIT]      = dir_rd;
      h_cmd[ADDR_W-1:0]   = idx;
   end

endmodule

// File: rtl/csr_xdom_bridge_chk.sv
`timescale 1ns/1ps
module csr_xdom_bridge_chk #(
   parameter int DATA_W = 32
) (
   input logic              hclk,
   input logic              hrst_n,
   input logic              iclk,
   input logic              irst_n,
   input logic [DATA_W-1:0] h_cmd,
   input logic [DATA_W-1:0] h_data,
   input logic              reg_en,
   input logic              reg_we
);

   localparam int BUSY_BIT = DATA_W - 1;
   localparam int DIR_BIT  = DATA_W - 2;

   AST_ONE_STROBE: assert property (@(posedge iclk) disable iff (!irst_n) reg_en |=> !reg_en); // R2

   AST_STROBE_WHILE_BUSY: assert property (@(posedge iclk) disable iff (!irst_n || !hrst_n) reg_en |-> h_cmd[BUSY_BIT]); // R7

   AST_WE_FOLLOWS_DIR: assert property (@(posedge iclk) disable iff (!irst_n || !hrst_n) reg_en |-> (reg_we == !h_cmd[DIR_BIT])); // R5

   AST_CMD_FROZEN: assert property (@(posedge hclk) disable iff (!hrst_n) (h_cmd[BUSY_BIT] && $past(h_cmd[BUSY_BIT])) |-> $stable(h_cmd[DIR_BIT:0])); // R8

   AST_WDATA_FROZEN: assert property (@(posedge hclk) disable iff (!hrst_n) (h_cmd[BUSY_BIT] && $past(h_cmd[BUSY_BIT]) && !h_cmd[DIR_BIT]) |-> $stable(h_data)); // R8

   AST_RSVD_ZERO: assert property (@(posedge hclk) disable iff (!hrst_n) h_cmd[DIR_BIT-1:8] == '0); // R4

endmodule

bind csr_xdom_bridge csr_xdom_bridge_chk #(.DATA_W(DATA_W)) u_chk (
   .hclk(hclk), .hrst_n(hrst_n), .iclk(iclk), .irst_n(irst_n),
   .h_cmd(h_cmd), .h_data(h_data), .reg_en(reg_en), .reg_we(reg_we)
);

// File: tb/sim_csr_xdom_bridge.sv
`timescale 1ns/1ps
module sim_csr_xdom_bridge;

   logic        hclk = 1'b0, iclk = 1'b0;
   logic        hrst_n = 1'b0, irst_n = 1'b0;
   logic        h_wr = 1'b0, h_sel = 1'b0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_cmd, h_data;
   logic        reg_en, reg_we;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] rd_q = '0;

   int n_cmp = 0, n_bad = 0;
   int strobes = 0;
   logic [7:0]  last_addr = '0;
   logic        last_we = 1'b0;
   logic [31:0] last_wdata = '0;
   logic [31:0] bank [256];
   logic [31:0] shadow [256];

   always #2 hclk = ~hclk;        // 250 MHz host clock
   always #3.65 iclk = ~iclk;     // unrelated register clock

   csr_xdom_bridge u0 (
      .hclk(hclk), .hrst_n(hrst_n), .h_wr(h_wr), .h_sel(h_sel),
      .h_wdata(h_wdata), .h_cmd(h_cmd), .h_data(h_data),
      .iclk(iclk), .irst_n(irst_n), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_q)
   );

   // register bank model, read latency of one iclk cycle
   always @(posedge iclk) begin
      if (reg_en) begin
         strobes    <= strobes + 1;
         last_addr  <= reg_addr;
         last_we    <= reg_we;
         last_wdata <= reg_wdata;
         if (reg_we) bank[reg_addr] <= reg_wdata;
         rd_q <= bank[reg_addr];
      end
   end

   function automatic logic [31:0] cmd_word(bit start, bit rd, logic [7:0] a);
      return {start, rd, 22'd0, a};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic host_write(logic sel, logic [31:0] v);
      @(negedge hclk);
      h_wr = 1'b1; h_sel = sel; h_wdata = v;
      @(negedge hclk);
      h_wr = 1'b0;
   endtask

   task automatic wait_idle(string req);
      for (int i = 0; i < 400; i++) begin
         if (!h_cmd[31]) return;
         @(negedge hclk);
      end
      chk(1'b0, req, h_cmd, 32'h0);
   endtask

   task automatic do_write(logic [7:0] a, logic [31:0] v, string req);
      int s0;
      host_write(1'b1, v);
      s0 = strobes;
      host_write(1'b0, cmd_word(1'b1, 1'b0, a));
      wait_idle(req);
      repeat (4) @(negedge hclk);
      shadow[a] = v;
      chk(strobes == s0 + 1, req, 32'(strobes - s0), 32'd1);
      chk(bank[a] == v && last_we && last_addr == a, req, bank[a], v);
   endtask

   task automatic do_read(logic [7:0] a, string req);
      host_write(1'b0, cmd_word(1'b1, 1'b1, a));
      wait_idle(req);
      chk(h_data == shadow[a], req, h_data, shadow[a]);   // first idle cycle
   endtask

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      summary();
   end

   initial begin
      logic [7:0]  a;
      logic [31:0] v;
      int s0;
      void'($urandom(32'h5EED_0A1C));
      for (int i = 0; i < 256; i++) begin bank[i] = '0; shadow[i] = '0; end
      repeat (5) @(negedge hclk);
      hrst_n = 1'b1; irst_n = 1'b1;
      @(negedge hclk);
      chk(h_cmd == 32'h0, "R1", h_cmd, 32'h0);
      chk(h_data == 32'h0, "R1", h_data, 32'h0);

      // R3: no-start write only updates fields
      s0 = strobes;
      host_write(1'b0, cmd_word(1'b0, 1'b1, 8'h5A));
      repeat (20) @(negedge hclk);
      chk(h_cmd == 32'h4000_005A, "R3", h_cmd, 32'h4000_005A);
      chk(strobes == s0, "R3", 32'(strobes), 32'(s0));

      // R4: reserved bits ignored
      host_write(1'b0, 32'h3FFF_FF00 | 32'h0000_0011);
      chk(h_cmd == 32'h0000_0011, "R4", h_cmd, 32'h0000_0011);

      // R5 directed corners
      do_write(8'h00, 32'hFFFF_FFFF, "R5");
      do_write(8'hFF, 32'hA5A5_0F0F, "R5");

      // R7: busy held during handshake
      host_write(1'b0, cmd_word(1'b1, 1'b1, 8'hFF));
      chk(h_cmd[31] == 1'b1, "R7", h_cmd, 32'hC000_00FF);
      repeat (3) @(negedge hclk);
      chk(h_cmd[31] == 1'b1, "R7", h_cmd, 32'hC000_00FF);
      wait_idle("R7");
      chk(h_data == 32'hA5A5_0F0F, "R6", h_data, 32'hA5A5_0F0F);

      // R8: writes during an access are ignored
      host_write(1'b1, 32'h1234_5678);
      s0 = strobes;
      host_write(1'b0, cmd_word(1'b1, 1'b0, 8'h42));
      host_write(1'b1, 32'hDEAD_BEEF);
      host_write(1'b0, cmd_word(1'b1, 1'b1, 8'h99));
      chk(h_cmd == 32'h8000_0042, "R8", h_cmd, 32'h8000_0042);
      wait_idle("R8");
      repeat (4) @(negedge hclk);
      shadow[8'h42] = 32'h1234_5678;
      chk(strobes == s0 + 1, "R8", 32'(strobes - s0), 32'd1);
      chk(bank[8'h42] == 32'h1234_5678, "R8", bank[8'h42], 32'h1234_5678);
      chk(h_data == 32'h1234_5678, "R8", h_data, 32'h1234_5678);
      chk(bank[8'h99] == 32'h0, "R8", bank[8'h99], 32'h0);

      // R6: read of an unwritten index returns zero
      do_read(8'h77, "R6");

      // R9: random back-to-back write then read
      for (int k = 0; k < 40; k++) begin
         a = 8'($urandom);
         v = $urandom;
         do_write(a, v, "R9");
         do_read(a, "R9");
         if (k % 5 == 4) do_read(8'($urandom), "R6");
      end

      summary();
   end

endmodule